// File: doc/BRIEF.md
# Pin Level and Timer Event Status Word

This block produces a read-only 32-bit status word for a processor's global register file. Seven external pins (four interrupt inputs and three general I/O pins) pass through a two-stage synchronizer. Their true electrical levels appear in the low bits of the word, with no polarity inversion applied.

Two sticky flags share the word with the pin levels. The event flag records that the third I/O pin reached its programmed level while the timing mode is selected. The equal flag records that a 16-bit compare value matched the free-running timer in either of the two timer-related modes.

Software clears both flags by writing the clear bit of the control register as 1. Any write to the compare register also clears them, as a side effect. The timer, the compare register and interrupt generation sit outside this block. The block receives their current values and write strobes as inputs.

Top module: `pin_status_word`

## Requirements
- R1: The low bits of `status_word` report pin levels, with 1 meaning electrically high. Bits 0..3 are `int_pins[0]`..`int_pins[3]`, and bits 4..6 are `io_pins[0]`..`io_pins[2]`.
- R2: Bits 31 down to 9 of `status_word` always read as 0.
- R3: When `rst` is high at a rising edge, `status_word`, both flags and both synchronizer stages become 0 after that edge, whatever the pins are doing.
- R4: A pin level driven between two rising edges first appears in `status_word` after the third of the following rising edges. It is not yet visible after the second.
- R5: The reported pin levels do not change when `io3_polarity` or `io3_mode` change.
- R6: Bit 8 (event flag) sets when `io3_mode` is 2'b01 (timing) and the synchronized level of `io_pins[2]` equals `io3_polarity`. The flag register is loaded at the edge where this holds, and bit 8 shows the flag after the next edge.
- R7: Bit 7 (equal flag) sets when `io3_mode` is 2'b01 (timing) or 2'b10 (timer interrupt) and `cmp_value` equals `timer_value`. The bit shows the flag with the same one-edge delay as bit 8.
- R8: With `io3_mode` 2'b00 (plain) or 2'b11 (spare), neither flag sets, even if both set conditions hold.
- R9: Once set, a flag stays set after its set condition goes away, until a clear occurs.
- R10: A clear happens when `ctl_wr` is high with `ctl_clr_bit` = 1 at an edge. When `ctl_wr` is high with `ctl_clr_bit` = 0, the flags do not change.
- R11: A clear also happens when `cmp_wr` is high at an edge, whatever the compare data.
- R12: A clear at the same edge as a set condition wins at that edge. If the set condition still holds at the next edge, the flag sets again there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_pins | input | 4 | Raw interrupt input pins 1..4 |
| io_pins | input | 3 | Raw general I/O pins 1..3 |
| io3_mode | input | 2 | Mode of I/O pin 3: 00 plain, 01 timing, 10 timer interrupt, 11 spare |
| io3_polarity | input | 1 | Programmed level of I/O pin 3 for the event flag |
| cmp_value | input | 16 | Low 16 bits of the compare register |
| timer_value | input | 16 | Low 16 bits of the timer register |
| cmp_wr | input | 1 | Write strobe of the compare register |
| ctl_wr | input | 1 | Write strobe of the control register |
| ctl_clr_bit | input | 1 | Value of the flag-clear bit in the control write data |
| status_word | output | 32 | Assembled status word |

## Verification
The hardest situation to reach is a clear that lands on an edge where a set condition is still held, followed by the flag setting again one edge later. The directed part holds a compare match steady and pulses the control clear for a single cycle. It then samples the word at both edges that follow. The random part draws compare and timer values from a range of four values, so matches are frequent. It also mixes in rare clears from both sources and sudden mode changes. A cycle-level expected model in the bench checks every field on every cycle.

// File: rtl/pin_status_pkg.sv
package pin_status_pkg;
    localparam int unsigned STATUS_W = 32;
    localparam int unsigned INT_N    = 4;
    localparam int unsigned IO_N     = 3;
    localparam int unsigned LEVEL_N  = INT_N + IO_N;
    localparam int unsigned EQ_BIT   = LEVEL_N;
    localparam int unsigned EVT_BIT  = LEVEL_N + 1;
    localparam int unsigned IO3_IDX  = LEVEL_N - 1;

    typedef enum logic [1:0] {
        IO3_PLAIN     = 2'd0,
        IO3_TIMING    = 2'd1,
        IO3_TIMER_IRQ = 2'd2,
        IO3_SPARE     = 2'd3
    } io3_mode_e;

    typedef struct packed {
        logic evt;
        logic eq;
    } sticky_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d.s1 = raw;
        chain_d.s2 = chain_q.s1;
    end

    // R3: both stages return to zero on reset
    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign synced = chain_q.s2;
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags
    import pin_status_pkg::*;
#(
    parameter int unsigned MATCH_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               io3_level,
    input  logic [1:0]         mode,
    input  logic               polarity,
    input  logic [MATCH_W-1:0] cmp_value,
    input  logic [MATCH_W-1:0] timer_value,
    input  logic               clear,
    output sticky_t            flags
);
    io3_mode_e mode_e;
    logic      hit_evt;
    logic      hit_eq;
    sticky_t   flags_d, flags_q;

    always_comb begin
        mode_e  = io3_mode_e'(mode);
        // R6: event condition armed only in timing mode
        hit_evt = (mode_e == IO3_TIMING) && (io3_level == polarity);
        // R7, R8: match armed in timing and timer-interrupt modes
        hit_eq  = ((mode_e == IO3_TIMING) || (mode_e == IO3_TIMER_IRQ)) &&
                  (cmp_value == timer_value);
        flags_d = flags_q;
        if (clear) begin
            // R12: clear takes priority over a coincident set
            flags_d = '0;
        end else begin
            // R9: sticky accumulation
            flags_d.evt = flags_q.evt | hit_evt;
            flags_d.eq  = flags_q.eq  | hit_eq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/pin_status_word.sv
module pin_status_word
    import pin_status_pkg::*;
#(
    parameter int unsigned MATCH_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [INT_N-1:0]    int_pins,
    input  logic [IO_N-1:0]     io_pins,
    input  logic [1:0]          io3_mode,
    input  logic                io3_polarity,
    input  logic [MATCH_W-1:0]  cmp_value,
    input  logic [MATCH_W-1:0]  timer_value,
    input  logic                cmp_wr,
    input  logic                ctl_wr,
    input  logic                ctl_clr_bit,
    output logic [STATUS_W-1:0] status_word
);
    logic [LEVEL_N-1:0]  level_sync;
    logic                flag_clear;
    sticky_t             flags_q;
    logic [STATUS_W-1:0] status_d, status_q;

    // R1: interrupt pins below, I/O pins above
    pin_sync #(.W(LEVEL_N)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    ({io_pins, int_pins}),
        .synced (level_sync)
    );

    // R10, R11: two clear sources
    assign flag_clear = cmp_wr | (ctl_wr & ctl_clr_bit);

    sticky_flags #(.MATCH_W(MATCH_W)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .io3_level   (level_sync[IO3_IDX]),
        .mode        (io3_mode),
        .polarity    (io3_polarity),
        .cmp_value   (cmp_value),
        .timer_value (timer_value),
        .clear       (flag_clear),
        .flags       (flags_q)
    );

    // R2, R5: reserved bits zero, levels bypass polarity
    always_comb begin
        status_d                = '0;
        status_d[LEVEL_N-1:0]   = level_sync;
        status_d[EQ_BIT]        = flags_q.eq;
        status_d[EVT_BIT]       = flags_q.evt;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    assign status_word = status_q;
endmodule

// File: rtl/pin_status_word_chk.sv
module pin_status_word_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  int_pins,
    input logic [2:0]  io_pins,
    input logic [1:0]  io3_mode,
    input logic        cmp_wr,
    input logic        ctl_wr,
    input logic        ctl_clr_bit,
    input logic [31:0] status_word,
    input logic [1:0]  flag_bits
);
    logic [1:0] run_cnt;
    logic       clr_now;

    assign clr_now = cmp_wr || (ctl_wr && ctl_clr_bit);

    always_ff @(posedge clk) begin
        if (rst)                run_cnt <= 2'd0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        status_word[31:9] == 23'd0);

    p_reset_clear_r3: assert property (@(posedge clk)
        rst |=> (status_word == 32'd0) && (flag_bits == 2'b00));

    p_level_pipe_r4: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == 2'd3) |-> status_word[6:0] == $past({io_pins, int_pins}, 3));

    p_event_mode_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_bits[1]) |-> $past(io3_mode) == 2'b01);

    p_flags_to_word_r7: assert property (@(posedge clk) disable iff (rst)
        (run_cnt != 2'd0) |-> status_word[8:7] == $past(flag_bits));

    p_mode_gate_r8: assert property (@(posedge clk) disable iff (rst)
        ((io3_mode == 2'b00) || (io3_mode == 2'b11)) && (flag_bits == 2'b00)
        |=> flag_bits == 2'b00);

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !clr_now |=> (flag_bits & $past(flag_bits)) == $past(flag_bits));

    p_clear_wins_r12: assert property (@(posedge clk) disable iff (rst)
        clr_now |=> flag_bits == 2'b00);
endmodule

bind pin_status_word pin_status_word_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .int_pins    (int_pins),
    .io_pins     (io_pins),
    .io3_mode    (io3_mode),
    .cmp_wr      (cmp_wr),
    .ctl_wr      (ctl_wr),
    .ctl_clr_bit (ctl_clr_bit),
    .status_word (status_word),
    .flag_bits   (flags_q)
);

// File: tb/pin_status_word_bench.sv
`timescale 1ns/1ps
module pin_status_word_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  int_pins;
    logic [2:0]  io_pins;
    logic [1:0]  io3_mode;
    logic        io3_polarity;
    logic [15:0] cmp_value;
    logic [15:0] timer_value;
    logic        cmp_wr;
    logic        ctl_wr;
    logic        ctl_clr_bit;
    logic [31:0] status_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pin_status_word u_pin_status_word (
        .clk (clk), .rst (rst), .int_pins (int_pins), .io_pins (io_pins),
        .io3_mode (io3_mode), .io3_polarity (io3_polarity),
        .cmp_value (cmp_value), .timer_value (timer_value),
        .cmp_wr (cmp_wr), .ctl_wr (ctl_wr), .ctl_clr_bit (ctl_clr_bit),
        .status_word (status_word)
    );

    function automatic logic [31:0] exp_word(input logic [6:0] lv, input logic eq, input logic evt);
        return {23'd0, evt, eq, lv};
    endfunction

    function automatic logic exp_clear(input logic cw, input logic w, input logic b);
        return cw | (w & b);
    endfunction

    // expected model built from the requirement timing
    logic [6:0]  m_s1, m_s2;
    logic        m_eq, m_evt;
    logic [31:0] m_word;
    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_eq <= 1'b0; m_evt <= 1'b0; m_word <= '0;
        end else begin
            m_s1   <= {io_pins, int_pins};
            m_s2   <= m_s1;
            m_word <= exp_word(m_s2, m_eq, m_evt);
            if (exp_clear(cmp_wr, ctl_wr, ctl_clr_bit)) begin
                m_evt <= 1'b0;
                m_eq  <= 1'b0;
            end else begin
                m_evt <= m_evt | ((io3_mode == 2'b01) && (m_s2[6] == io3_polarity));
                m_eq  <= m_eq  | (((io3_mode == 2'b01) || (io3_mode == 2'b10)) &&
                                  (cmp_value == timer_value));
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; int_pins = 4'hF; io_pins = 3'h7; io3_mode = 2'b00;
        io3_polarity = 1'b0; cmp_value = 16'h0001; timer_value = 16'h0002;
        cmp_wr = 1'b0; ctl_wr = 1'b0; ctl_clr_bit = 1'b0;
        cyc(3);
        chk("R3 reset word", status_word, 32'd0);

        // R4: release reset with all pins high
        rst = 1'b0;
        cyc(2);
        chk("R4 not visible after second edge", status_word, 32'd0);
        cyc(1);
        chk("R4 R1 visible after third edge", status_word, 32'h0000_007F);
        int_pins = 4'h0;
        cyc(2);
        chk("R4 old level held two edges", {28'd0, status_word[3:0]}, 32'hF);
        cyc(1);
        chk("R4 falling level after third edge", {28'd0, status_word[3:0]}, 32'h0);

        // R5 and R1: fixed pattern under every mode and polarity
        io_pins = 3'b101; int_pins = 4'b0110;
        cyc(3);
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 4; m++) begin
                io3_polarity = p[0];
                io3_mode     = m[1:0];
                cyc(1);
                chk("R5 R1 levels ignore polarity and mode",
                    {25'd0, status_word[6:0]}, 32'h56);
            end
        end
        io3_mode = 2'b00;
        ctl_wr = 1'b1; ctl_clr_bit = 1'b1;
        cyc(1);
        ctl_wr = 1'b0; ctl_clr_bit = 1'b0;
        cyc(2);
        chk("R10 flags cleared", {30'd0, status_word[8:7]}, 32'd0);

        // R6: event flag, mismatch then match
        io_pins = 3'b100; cyc(3);
        io3_mode = 2'b01; io3_polarity = 1'b0;
        cyc(3);
        chk("R6 no event on polarity mismatch", {31'd0, status_word[8]}, 32'd0);
        io3_polarity = 1'b1;
        cyc(1);
        chk("R6 event not yet in word", {31'd0, status_word[8]}, 32'd0);
        cyc(1);
        chk("R6 event in word", {30'd0, status_word[8:7]}, 32'b10);

        // R9: condition removed
        io3_polarity = 1'b0; io3_mode = 2'b00;
        cyc(4);
        chk("R9 event sticky", {31'd0, status_word[8]}, 32'd1);

        // R7: equal flag in timer-interrupt mode
        io3_mode = 2'b10; cmp_value = 16'h1234; timer_value = 16'h1234;
        cyc(2);
        chk("R7 equal flag set", {30'd0, status_word[8:7]}, 32'b11);
        timer_value = 16'h1235;
        cyc(3);
        chk("R9 equal sticky", {31'd0, status_word[7]}, 32'd1);

        // R10: control write without the clear bit
        ctl_wr = 1'b1; ctl_clr_bit = 1'b0;
        cyc(1);
        ctl_wr = 1'b0;
        cyc(2);
        chk("R10 write with clear bit 0 ignored", {30'd0, status_word[8:7]}, 32'b11);
        io3_mode = 2'b00;
        ctl_wr = 1'b1; ctl_clr_bit = 1'b1;
        cyc(1);
        ctl_wr = 1'b0; ctl_clr_bit = 1'b0;
        cyc(1);
        chk("R10 clear via control bit", {30'd0, status_word[8:7]}, 32'd0);

        // R8: both conditions true but gated mode
        timer_value = 16'h1234; io3_polarity = 1'b1;
        cyc(4);
        chk("R8 plain mode sets nothing", {30'd0, status_word[8:7]}, 32'd0);
        io3_mode = 2'b11;
        cyc(4);
        chk("R8 spare mode sets nothing", {30'd0, status_word[8:7]}, 32'd0);

        // R11: compare write clears both flags
        io3_mode = 2'b01;
        cyc(2);
        chk("R11 both flags set first", {30'd0, status_word[8:7]}, 32'b11);
        io3_mode = 2'b00; cmp_wr = 1'b1; cmp_value = 16'h0F0F;
        cyc(1);
        cmp_wr = 1'b0;
        cyc(1);
        chk("R11 compare write clears", {30'd0, status_word[8:7]}, 32'd0);
        cyc(2);
        chk("R11 stays clear", {30'd0, status_word[8:7]}, 32'd0);

        // R12: clear while match held
        io3_mode = 2'b10; cmp_value = 16'h0ABC; timer_value = 16'h0ABC;
        cyc(2);
        chk("R12 equal set before clear", {31'd0, status_word[7]}, 32'd1);
        ctl_wr = 1'b1; ctl_clr_bit = 1'b1;
        cyc(1);
        ctl_wr = 1'b0; ctl_clr_bit = 1'b0;
        cyc(1);
        chk("R12 clear wins", {31'd0, status_word[7]}, 32'd0);
        cyc(1);
        chk("R12 sets again next edge", {31'd0, status_word[7]}, 32'd1);

        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            chk("R1 R4 R5 levels", {25'd0, status_word[6:0]}, {25'd0, m_word[6:0]});
            chk("R7 equal flag", {31'd0, status_word[7]}, {31'd0, m_word[7]});
            chk("R6 event flag", {31'd0, status_word[8]}, {31'd0, m_word[8]});
            chk("R2 reserved zero", {9'd0, status_word[31:9]}, 32'd0);
            int_pins     = 4'($urandom);
            io_pins      = 3'($urandom);
            if ($urandom % 8 == 0) io3_mode = 2'($urandom);
            io3_polarity = 1'($urandom);
            cmp_value    = 16'($urandom % 4);
            timer_value  = 16'($urandom % 4);
            cmp_wr       = ($urandom % 16 == 0);
            ctl_wr       = ($urandom % 8 == 0);
            ctl_clr_bit  = 1'($urandom);
            cyc(1);
        end
        summary();
    end
endmodule